// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing access port of a video display controller. The host sees two byte offsets only. A write to the control offset chooses which internal register is addressed next. A read of the control offset returns a status byte whose top bit tells the host whether the controller can take a data access. The data offset then reads or writes the chosen register. The internal register file has 38 byte-wide entries. The highest entry keeps two sync polarity bits, and those bits drive the `hsync_pol` and `vsync_pol` outputs.

Each selection and each accepted data access starts a busy window of `BUSY_CYCLES` clocks. During this window the ready bit reads 0 and any data access is dropped. The host is expected to select a register, poll status until the ready bit returns, and only then touch the data offset. When ready comes back, an active-low interrupt asserts. It stays asserted until the host reads status, so the host can wait on the interrupt instead of polling. Read data is registered and appears on `bus_rdata` one clock after the read strobe. It then holds until the next read.

Top module: `ind_reg_port`

## Requirements
- R1: After reset, the status byte reads 0x80, `irq_n` is 1, all 38 register entries read 0, and both polarity outputs are 0.
- R2: A write to offset 0 is accepted at any time, even while busy. It loads the 8-bit index and (re)starts a busy window. From the next clock, status reads 0x00 for BUSY_CYCLES cycles and then reads 0x80. Status bits 6 to 0 are always 0, and a status read does not change ready.
- R3: When ready is 1, a write to offset 1 stores into entry `index` (0 to 37). A read of offset 1 returns that entry on `bus_rdata` in the cycle after the strobe. Either access starts a busy window as in R2.
- R4: Entry 37 keeps only bit 7 (horizontal sync polarity, driven on `hsync_pol`) and bit 6 (vertical sync polarity, driven on `vsync_pol`). Its other bits always read 0.
- R5: `irq_n` goes to 0 on the same clock edge where ready changes from 0 to 1. It stays at 0 until a status read. It never falls at any other time.
- R6: A status read sets `irq_n` to 1 on its clock edge. If ready rises on that same edge, `irq_n` goes to 0 instead.
- R7: A data access while ready is 0 is ignored. It writes nothing, a read returns 0xFF, and the busy window is neither restarted nor extended.
- R8: With a selected index above 37, a data read returns 0xFF and a write changes no entry. The access still starts a busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_addr | input | 1 | Offset: 0 = control/status, 1 = data |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data or register index |
| bus_rdata | output | 8 | Registered read data, held until the next read |
| irq_n | output | 1 | Active-low ready interrupt |
| hsync_pol | output | 1 | Horizontal sync polarity (entry 37, bit 7) |
| vsync_pol | output | 1 | Vertical sync polarity (entry 37, bit 6) |

## Verification
The main select/write/read path is driven from a vector table. The table covers all-ones, all-zeros and mixed data at the lowest entry, the highest plain entry and a middle entry, which separates address decoding from data-path faults. Entry 37 is written with patterns whose low bits differ, which exposes a missing mask. Indices 38 and 255 are also written, which exposes index truncation or aliasing. Directed sequences then place accesses exactly one cycle before and after the end of a busy window. They also issue back-to-back selections and make a status read on the very edge where ready rises. This distinguishes an off-by-one window length, a restart caused by an ignored access, and the wrong priority between interrupt set and release.

// File: rtl/rp_pkg.sv
// Package: shared constants and types for the indirect register access port.
// Assumes an 8-bit host data bus by default; all widths remain overridable.
package rp_pkg;

    // Host-visible offsets of the two-address port.
    typedef enum logic {
        OFS_CTRL = 1'b0,
        OFS_DATA = 1'b1
    } port_ofs_e;

    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_NUM_REGS = 38;
    localparam int unsigned DEF_BUSY     = 4;

endpackage

// File: rtl/rp_busy_timer.sv
// Module: busy window timer.
// Clears ready for BUSY_CYCLES clocks after each start pulse. A new start
// always reloads the window. rise_next flags that ready becomes 1 on the
// coming edge. Assumes BUSY_CYCLES >= 1.
module rp_busy_timer #(
    parameter int unsigned BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready,
    output logic rise_next
);
    localparam int unsigned CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Ready returns on the next edge unless a new start arrives.
    assign rise_next = !ready && (cnt_q == '0) && !start;

    // Count down the busy window and restore ready at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b1;
            cnt_q <= '0;
        end else if (start) begin
            ready <= 1'b0;
            cnt_q <= RELOAD;
        end else if (!ready) begin
            if (cnt_q == '0) begin
                ready <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rp_irq_ctl.sv
// Module: ready interrupt control.
// Drives an active-low interrupt that asserts when ready rises and is
// released by a status read. Assertion wins over release on the same edge.
module rp_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_rise,
    input  logic release_req,
    output logic irq_n
);
    // Hold the interrupt until the host acknowledges it through status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (ready_rise) begin
            irq_n <= 1'b0;
        end else if (release_req) begin
            irq_n <= 1'b1;
        end
    end

endmodule

// File: rtl/rp_reg_bank.sv
// Module: internal register file.
// NUM_REGS entries of DATA_W bits. The entry at POL_IDX keeps only its two
// top bits (sync polarities). Indices at or above NUM_REGS are out of range:
// they read all ones and ignore writes. Assumes IDX_W can hold NUM_REGS.
module rp_reg_bank #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 38,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned POL_IDX  = NUM_REGS - 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             idx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rd_word,
    output logic                         in_range,
    output logic [NUM_REGS*DATA_W-1:0]   flat,
    output logic                         hpol,
    output logic                         vpol
);
    localparam logic [DATA_W-1:0] POL_MASK = {2'b11, {(DATA_W-2){1'b0}}};
    localparam logic [DATA_W-1:0] ALL_MASK = '1;

    logic [DATA_W-1:0] words [NUM_REGS];

    // An index is valid only below the entry count.
    assign in_range = (idx < IDX_W'(NUM_REGS));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        localparam logic [DATA_W-1:0] KEEP = (g == POL_IDX) ? POL_MASK : ALL_MASK;
        logic [DATA_W-1:0] q;

        // Store masked write data when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && in_range && (idx == IDX_W'(g))) begin
                q <= wdata & KEEP;
            end
        end

        assign words[g]                    = q;
        assign flat[g*DATA_W +: DATA_W]    = q;
    end

    // Select the addressed entry, all ones when out of range.
    always_comb begin
        rd_word = '1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_word = words[i];
            end
        end
    end

    assign hpol = words[POL_IDX][DATA_W-1];
    assign vpol = words[POL_IDX][DATA_W-2];

endmodule

// File: rtl/ind_reg_port.sv
// Module: indirect register access port (top).
// Decodes the two-offset host bus into index selection, status reads and
// data accesses. It gates data accesses with the busy window, and registers
// read data for one-cycle-later pickup. Assumes single-cycle bus_sel strobes.
module ind_reg_port #(
    parameter int unsigned DATA_W      = rp_pkg::DEF_DATA_W,
    parameter int unsigned NUM_REGS    = rp_pkg::DEF_NUM_REGS,
    parameter int unsigned BUSY_CYCLES = rp_pkg::DEF_BUSY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n,
    output logic              hsync_pol,
    output logic              vsync_pol
);
    import rp_pkg::*;

    localparam int unsigned IDX_W   = DATA_W;
    localparam int unsigned POL_IDX = NUM_REGS - 1;

    port_ofs_e                   ofs;
    logic                        sel_wr;
    logic                        stat_rd;
    logic                        data_acc;
    logic                        data_ok;
    logic                        ready_w;
    logic                        rise_w;
    logic                        in_range_w;
    logic [IDX_W-1:0]            idx_q;
    logic [DATA_W-1:0]           rd_word_w;
    logic [DATA_W-1:0]           status_w;
    logic [NUM_REGS*DATA_W-1:0]  bank_flat_w;

    // Decode the host strobe into its four access kinds.
    assign ofs      = port_ofs_e'(bus_addr);
    assign sel_wr   = bus_sel && bus_wr  && (ofs == OFS_CTRL);
    assign stat_rd  = bus_sel && !bus_wr && (ofs == OFS_CTRL);
    assign data_acc = bus_sel && (ofs == OFS_DATA);
    assign data_ok  = data_acc && ready_w;
    assign status_w = {ready_w, {(DATA_W-1){1'b0}}};

    // Capture the register index on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (sel_wr) begin
            idx_q <= bus_wdata[IDX_W-1:0];
        end
    end

    // Register read data for status and data reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (stat_rd) begin
            bus_rdata <= status_w;
        end else if (data_acc && !bus_wr) begin
            bus_rdata <= (data_ok && in_range_w) ? rd_word_w : '1;
        end
    end

    rp_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sel_wr || data_ok),
        .ready     (ready_w),
        .rise_next (rise_w)
    );

    rp_irq_ctl u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_rise  (rise_w),
        .release_req (stat_rd),
        .irq_n       (irq_n)
    );

    rp_reg_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .POL_IDX  (POL_IDX)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_ok && bus_wr),
        .idx      (idx_q),
        .wdata    (bus_wdata),
        .rd_word  (rd_word_w),
        .in_range (in_range_w),
        .flat     (bank_flat_w),
        .hpol     (hsync_pol),
        .vpol     (vsync_pol)
    );

endmodule

// File: rtl/rp_port_checker.sv
// Module: property checker for ind_reg_port, attached by bind.
// Observes host strobes, ready, interrupt, read data and register contents.
module rp_port_checker #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 38
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_addr,
    input logic                        bus_wr,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic                        irq_n,
    input logic                        ready,
    input logic                        idx_in_range,
    input logic [NUM_REGS*DATA_W-1:0]  bank_flat
);
    logic sel_wr, stat_rd, data_acc;
    assign sel_wr   = bus_sel && bus_wr && !bus_addr;
    assign stat_rd  = bus_sel && !bus_wr && !bus_addr;
    assign data_acc = bus_sel && bus_addr;

    AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> !ready); // R2
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (bus_rdata[DATA_W-2:0] == '0)); // R2
    AST_DATA_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ready) |=> !ready); // R3
    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !irq_n); // R5
    AST_IRQ_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $rose(ready)); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !stat_rd) |=> !irq_n); // R5
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (irq_n || $rose(ready))); // R6
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && bus_wr && !ready) |=> $stable(bank_flat)); // R7
    AST_BUSY_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !bus_wr && !ready) |=> (bus_rdata == '1)); // R7
    AST_RANGE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && bus_wr && !idx_in_range) |=> $stable(bank_flat)); // R8
    AST_RANGE_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !bus_wr && !idx_in_range) |=> (bus_rdata == '1)); // R8

endmodule

bind ind_reg_port rp_port_checker #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .irq_n        (irq_n),
    .ready        (ready_w),
    .idx_in_range (in_range_w),
    .bank_flat    (bank_flat_w)
);

// File: tb/ind_reg_port_bench.sv
module ind_reg_port_bench;
    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_n, hsync_pol, vsync_pol;

    int checks = 0;
    int failures = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    ind_reg_port #(.DATA_W(8), .NUM_REGS(38), .BUSY_CYCLES(BUSY)) u_ind_reg_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .hsync_pol(hsync_pol), .vsync_pol(vsync_pol)
    );

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] wdata;
        logic [7:0] expd;
    } vec_t;

    // Select, write, reselect, read back: expected per R3, R4, R8.
    localparam vec_t VECS [8] = '{
        '{8'd0,   8'hA5, 8'hA5},
        '{8'd36,  8'h3C, 8'h3C},
        '{8'd18,  8'hFF, 8'hFF},
        '{8'd5,   8'h00, 8'h00},
        '{8'd37,  8'hFF, 8'hC0},
        '{8'd37,  8'h5A, 8'h40},
        '{8'd38,  8'h12, 8'hFF},
        '{8'd255, 8'h77, 8'hFF}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One-cycle strobe; called and returns at a falling edge.
    task automatic op(input logic a, input logic w, input logic [7:0] d);
        bus_sel = 1'b1; bus_addr = a; bus_wr = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        op(a, 1'b0, 8'h00);
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 pol", {6'd0, hsync_pol, vsync_pol}, 8'h00);
        rd(1'b0, rv); chk("R1 status", rv, 8'h80);
        for (int i = 0; i < 38; i++) begin
            op(1'b0, 1'b1, 8'(i)); idle(BUSY);
            rd(1'b1, rv); idle(BUSY);
            chk($sformatf("R1 entry %0d", i), rv, 8'h00);
        end

        // Table walk: R3 data path, R4 mask, R8 out of range
        for (int k = 0; k < 8; k++) begin
            op(1'b0, 1'b1, VECS[k].idx); idle(BUSY);
            op(1'b1, 1'b1, VECS[k].wdata); idle(BUSY);
            op(1'b0, 1'b1, VECS[k].idx); idle(BUSY);
            rd(1'b1, rv); idle(BUSY);
            chk($sformatf("R3/R4/R8 vec %0d idx %0d", k, VECS[k].idx), rv, VECS[k].expd);
        end
        // R4 polarity outputs after entry 37 = 0x40
        chk("R4 pol 40", {6'd0, hsync_pol, vsync_pol}, 8'h01);
        op(1'b0, 1'b1, 8'd37); idle(BUSY);
        op(1'b1, 1'b1, 8'h80); idle(BUSY);
        chk("R4 pol 80", {6'd0, hsync_pol, vsync_pol}, 8'h02);

        // R2 window length, R5/R6 interrupt timing
        rd(1'b0, rv);
        chk("R6 released", {7'd0, irq_n}, 8'h01);
        op(1'b0, 1'b1, 8'd5);
        rd(1'b0, rv); chk("R2 busy right after select", rv, 8'h00);
        idle(BUSY - 2);
        chk("R5 no irq before rise", {7'd0, irq_n}, 8'h01);
        rd(1'b0, rv); chk("R2 last busy cycle", rv, 8'h00);
        chk("R6 rise beats release", {7'd0, irq_n}, 8'h00);
        rd(1'b0, rv); chk("R2 ready after window", rv, 8'h80);
        chk("R6 release", {7'd0, irq_n}, 8'h01);
        op(1'b0, 1'b1, 8'd5); idle(BUSY);
        chk("R5 irq on rise", {7'd0, irq_n}, 8'h00);
        idle(6);
        chk("R5 irq held", {7'd0, irq_n}, 8'h00);
        rd(1'b0, rv);
        chk("R5 irq cleared", {7'd0, irq_n}, 8'h01);

        // R7 busy accesses ignored, no restart
        op(1'b0, 1'b1, 8'd10); idle(BUSY);
        op(1'b1, 1'b1, 8'h11);
        op(1'b1, 1'b1, 8'h22);
        rd(1'b1, rv); chk("R7 busy read ones", rv, 8'hFF);
        idle(BUSY - 2);
        rd(1'b1, rv); chk("R7 no restart, R3 readback", rv, 8'h11);
        idle(BUSY);

        // R2 reselect while busy restarts the window
        op(1'b0, 1'b1, 8'd6); idle(BUSY);
        op(1'b1, 1'b1, 8'h66); idle(BUSY);
        op(1'b0, 1'b1, 8'd3);
        op(1'b0, 1'b1, 8'd6);
        idle(BUSY - 1);
        rd(1'b1, rv); chk("R2 restart by reselect", rv, 8'hFF);
        idle(BUSY);
        rd(1'b1, rv); chk("R2 last index wins", rv, 8'h66);
        idle(BUSY);

        // R8 out-of-range write starts busy and aliases nothing
        op(1'b0, 1'b1, 8'd38); idle(BUSY);
        op(1'b1, 1'b1, 8'h99);
        rd(1'b0, rv); chk("R8 write starts busy", rv, 8'h00);
        idle(BUSY);
        op(1'b0, 1'b1, 8'd6); idle(BUSY);
        rd(1'b1, rv); idle(BUSY); chk("R8 no alias entry 6", rv, 8'h66);
        op(1'b0, 1'b1, 8'd0); idle(BUSY);
        rd(1'b1, rv); idle(BUSY); chk("R8 entry 0 intact", rv, 8'hA5);

        finish_run();
    end
endmodule